// File: doc/BRIEF.md
# UART Reference Clock Rate Selector

This block holds the clock-rate options register of an enhanced serial port and turns a fast master clock into the UART reference clock enable. The master clock runs at 14.7456 MHz, eight times the 1.8432 MHz base rate. The block emits a single-cycle enable pulse at one, two, four or eight times the base rate, which gives 1.8432, 3.6864, 7.3728 or 14.7456 MHz. With an unchanged UART baud divisor, these rates raise the top data rate from 115.2 kbaud to 230.4, 460.8 or 921.6 kbaud.

Software writes the two rate bits through a plain register port. Two active-high strap inputs, for double and quadruple speed, override the software value whenever either one is asserted. The software value is kept while the straps hold control and returns as soon as both straps are released. A read always shows the rate that is actually in use.

The selector is a two-state machine. In `SEL_SOFT` the rate follows software, and in `SEL_STRAP` it follows the straps. The `SOFT_TO_STRAP` transition fires when any strap is asserted, and `STRAP_TO_SOFT` fires when all straps are low. Each state otherwise holds. The enable divider restarts from zero whenever the effective rate changes.

Top module: `uart_refclk_sel`

## Requirements
- R1: After reset the effective rate is 00 (x1), the read value is 0, and the first enable pulse comes in the eighth master cycle after reset is released.
- R2: Rate code 00 gives one enable every 8 master cycles, 01 every 4, 10 every 2, and 11 gives an enable on every cycle.
- R3: With no strap asserted, a write sets the effective rate to write data bits [1:0] from the next clock edge on.
- R4: When a strap is asserted, the effective rate becomes {strap_quad, strap_dbl} from the next edge: the double strap gives 01, the quad strap gives 10 and both give 11. Writes made meanwhile do not change it.
- R5: Read data bits [1:0] always equal the effective rate, and bits above them read as zero. Write data bits above [1:0] have no effect.
- R6: A value written while a strap is asserted is kept, and it becomes the effective rate on the edge after all straps are released.
- R7: When the effective rate changes, the divider restarts: the first enable appears exactly one new period after the change. A write of the value already in effect does not disturb the pulse spacing.
- R8: For rates 00, 01 and 10 the enable is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 8x the base reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the options register |
| reg_wdata | input | 8 | Write data; only bits [1:0] are used |
| reg_rdata | output | 8 | Read data: effective rate in [1:0], zero above |
| strap_dbl | input | 1 | Strap forcing the x2 rate (adds x2 with the quad strap) |
| strap_quad | input | 1 | Strap forcing the x4 rate |
| clk_en | output | 1 | Single-cycle UART reference clock enable |
| rate_bits | output | 2 | Effective rate code |

## Verification
The assertions check several properties on every cycle: the strap override and the software write path one edge later, the match between read data and the effective rate, the continuous enable at rate 11, the absence of back-to-back enables at slower rates, and the suppressed pulse on the cycle a rate change takes effect. Other properties can only be shown by the bench's scenarios, which compare against a behavioural model on every clock. These are the exact pulse period for each rate, the first pulse after reset, the return of a value written under a strap once the straps are released, and the fact that rewriting the current value leaves the pulse phase alone.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
    localparam int RATE_W = 2;

    typedef enum logic [RATE_W-1:0] {
        MUL_X1 = 2'b00,
        MUL_X2 = 2'b01,
        MUL_X4 = 2'b10,
        MUL_X8 = 2'b11
    } mul_e;

    typedef enum logic {
        SEL_SOFT  = 1'b0,
        SEL_STRAP = 1'b1
    } sel_state_e;
endpackage

// File: rtl/refclk_soft_reg.sv
module refclk_soft_reg
    import refclk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output mul_e              soft_nxt
);
    mul_e soft_q;
    logic unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:RATE_W];

    always_comb begin
        soft_nxt = soft_q;
        if (wr_en) begin
            soft_nxt = mul_e'(wr_data[RATE_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_q <= MUL_X1;
        end else begin
            soft_q <= soft_nxt;
        end
    end
endmodule

// File: rtl/refclk_rate_sel.sv
module refclk_rate_sel
    import refclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strap_dbl,
    input  logic strap_quad,
    input  mul_e soft_nxt,
    output mul_e rate_q,
    output mul_e rate_nxt
);
    sel_state_e state_q;
    sel_state_e state_nxt;
    logic       any_strap;

    assign any_strap = strap_dbl | strap_quad;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEL_SOFT;
            rate_q  <= MUL_X1;
        end else begin
            state_q <= state_nxt;
            rate_q  <= rate_nxt;
        end
    end

    // transitions and outputs
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            SEL_SOFT:  if (any_strap)  state_nxt = SEL_STRAP; // SOFT_TO_STRAP
            SEL_STRAP: if (!any_strap) state_nxt = SEL_SOFT;  // STRAP_TO_SOFT
            default:   state_nxt = SEL_SOFT;
        endcase
    end

    always_comb begin
        unique case (state_nxt)
            SEL_STRAP: rate_nxt = mul_e'({strap_quad, strap_dbl});
            SEL_SOFT:  rate_nxt = soft_nxt;
            default:   rate_nxt = MUL_X1;
        endcase
    end
endmodule

// File: rtl/refclk_en_gen.sv
module refclk_en_gen
    import refclk_pkg::*;
#(
    parameter int MAX_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  mul_e rate_q,
    input  mul_e rate_nxt,
    output logic clk_en
);
    localparam int CNT_W  = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;
    localparam int N_RATE = 1 << RATE_W;

    logic [CNT_W-1:0] last_tbl [N_RATE];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    for (genvar i = 0; i < N_RATE; i++) begin : g_lim
        assign last_tbl[i] = CNT_W'((MAX_DIV >> i) - 1);
    end

    assign last   = last_tbl[rate_q];
    assign clk_en = (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rate_nxt != rate_q) begin
            cnt_q <= '0;
        end else if (cnt_q == last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/uart_refclk_sel.sv
module uart_refclk_sel
    import refclk_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int MAX_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              strap_dbl,
    input  logic              strap_quad,
    output logic              clk_en,
    output logic [1:0]        rate_bits
);
    mul_e soft_nxt;
    mul_e rate_q;
    mul_e rate_nxt;

    refclk_soft_reg #(.DATA_W(DATA_W)) u_soft (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_data  (reg_wdata),
        .soft_nxt (soft_nxt)
    );

    refclk_rate_sel u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_dbl  (strap_dbl),
        .strap_quad (strap_quad),
        .soft_nxt   (soft_nxt),
        .rate_q     (rate_q),
        .rate_nxt   (rate_nxt)
    );

    refclk_en_gen #(.MAX_DIV(MAX_DIV)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_q   (rate_q),
        .rate_nxt (rate_nxt),
        .clk_en   (clk_en)
    );

    assign rate_bits = rate_q;
    assign reg_rdata = {{(DATA_W-RATE_W){1'b0}}, rate_q};
endmodule

// File: rtl/refclk_sel_chk.sv
module refclk_sel_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              strap_dbl,
    input logic              strap_quad,
    input logic              clk_en,
    input logic [1:0]        rate_bits
);
    // R4
    a_r4_strap_force: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_dbl || strap_quad) |=> rate_bits == $past({strap_quad, strap_dbl}));

    // R3
    a_r3_soft_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !strap_dbl && !strap_quad) |=> rate_bits == $past(reg_wdata[1:0]));

    // R5
    a_r5_read_eff: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata == {{(DATA_W-2){1'b0}}, rate_bits});

    // R2
    a_r2_x8_every: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_bits == 2'b11) |-> clk_en);

    // R8
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && rate_bits != 2'b11) |=> (!clk_en || rate_bits == 2'b11));

    // R7
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rate_bits) && rate_bits != 2'b11) |-> !clk_en);
endmodule

bind uart_refclk_sel refclk_sel_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .strap_dbl  (strap_dbl),
    .strap_quad (strap_quad),
    .clk_en     (clk_en),
    .rate_bits  (rate_bits)
);

// File: tb/uart_refclk_sel_bench.sv
`timescale 1ns/1ps
module uart_refclk_sel_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       strap_dbl = 1'b0;
    logic       strap_quad = 1'b0;
    logic       clk_en;
    logic [1:0] rate_bits;

    int    n_run = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // behavioural reference
    int m_soft = 0;
    int m_rate = 0;
    int m_ticks = 0;

    always #2.5 clk = ~clk;

    uart_refclk_sel u_uart_refclk_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .strap_dbl  (strap_dbl),
        .strap_quad (strap_quad),
        .clk_en     (clk_en),
        .rate_bits  (rate_bits)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_soft = 0; m_rate = 0; m_ticks = 0;
        end else begin
            int strap_v;
            int new_rate;
            if (reg_wr) m_soft = reg_wdata % 4;
            strap_v  = (strap_quad ? 2 : 0) + (strap_dbl ? 1 : 0);
            new_rate = (strap_v != 0) ? strap_v : m_soft;
            if (new_rate != m_rate) m_ticks = 0;
            else m_ticks = m_ticks + 1;
            m_rate = new_rate;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int period;
        int exp_en;
        cyc++;
        period = 8 >> m_rate;
        exp_en = (((m_ticks + 1) % period) == 0) ? 1 : 0;
        check(cur_req, "rate_bits", int'(rate_bits), m_rate);
        check("R5", "reg_rdata", int'(reg_rdata), m_rate);
        check(cur_req, "clk_en", int'(clk_en), exp_en);
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_reg(logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        cur_req = "R1";
        idle(4);
        rst_n = 1'b1;
        // first pulse after reset: eighth cycle
        idle(7);
        check("R1", "first pulse", int'(clk_en), 1);
        idle(20);
        cur_req = "R3"; write_reg(8'h01); idle(13);
        cur_req = "R2"; write_reg(8'h02); idle(9);
        cur_req = "R2"; write_reg(8'h03); idle(6);
        cur_req = "R5"; write_reg(8'hFC); idle(10);
        check("R5", "upper write bits ignored", int'(reg_rdata), 0);
        cur_req = "R5"; write_reg(8'hA9); idle(3);
        cur_req = "R7"; write_reg(8'h01); idle(2);
        write_reg(8'h01); idle(9);
        cur_req = "R7"; write_reg(8'h00); write_reg(8'h02); idle(1);
        write_reg(8'h00); idle(11);
        // straps
        cur_req = "R4"; write_reg(8'h03);
        @(negedge clk); strap_dbl = 1'b1; idle(9);
        cur_req = "R6"; write_reg(8'h02); idle(4);
        cur_req = "R4"; strap_dbl = 1'b0; strap_quad = 1'b1; idle(7);
        strap_dbl = 1'b1; idle(5);
        cur_req = "R6"; write_reg(8'h00); idle(2);
        strap_dbl = 1'b0; strap_quad = 1'b0; idle(2);
        check("R6", "soft value back after release", int'(rate_bits), 0);
        idle(10);
        cur_req = "R6"; strap_quad = 1'b1; idle(3);
        write_reg(8'h01); strap_quad = 1'b0; idle(12);
        cur_req = "R8"; write_reg(8'h02); idle(12);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule